// File: doc/BRIEF.md
# Indexed Display Register Interface

This block is the I/O-port front end of a legacy-compatible display controller. A host issues byte reads, byte writes and 16-bit writes on a small port window. The block decodes each access onto one of four indexed register banks or onto a single miscellaneous output register. The four banks are a sequencer (5 registers), a CRT timing controller (25), a graphics controller (9) and an attribute controller (21). Each bank has an index latch that chooses which of its registers the data port reaches. The contents of every register leave the block as flat parallel vectors that the timing, memory and pixel blocks decode.

The attribute controller has no separate index port. One port takes both index and data, and a two-state phase machine sits behind it. The states are INDEX_PHASE (`AF_INDEX`, the reset state) and DATA_PHASE (`AF_DATA`). Three transitions are defined:

- INDEX_PHASE to DATA_PHASE: a write to the attribute port.
- DATA_PHASE to INDEX_PHASE: a write to the attribute port.
- Any state to INDEX_PHASE: a read of the status port ("status clear").

Bit 0 of the misc register moves the CRT index, CRT data and status ports between a colour set (0x3Dx) and a mono set (0x3Bx). A lock bit in CRT register 17 write-protects CRT registers 0 to 7. One field of register 7 stays writable while the lock is set.

Top module: `disp_reg_front`

## Requirements
- R1: After reset every bank register and index latch reads 0x00 and the misc register reads 0x01. The attribute phase machine is in INDEX_PHASE, so the first write to 0x3C0 lands in the attribute index latch.
- R2: The index/data port pairs are sequencer 0x3C4/0x3C5, graphics 0x3CE/0x3CF, and CRT 0x3D4/0x3D5 in colour mode or 0x3B4/0x3B5 in mono mode. A read of an index port returns the full byte last written there. A read of a data port returns the register that the latch selects.
- R3: A 16-bit write to an index port takes the index from bits 7:0 and the data from bits 15:8. It updates the latch and the addressed register in the same access.
- R4: A data write whose index is not below the bank size (5, 25, 9, 21) changes no register. A data-port read with such an index returns 0x00. The attribute bank decodes only index bits 4:0.
- R5: Each write to 0x3C0 toggles the phase, and a read of the active status port forces INDEX_PHASE. In INDEX_PHASE the write sets the attribute index latch, and bit 5 of that byte drives `attr_video_en`. In DATA_PHASE the write goes to the indexed attribute register. 0x3C0 reads back the index latch and 0x3C1 reads back the indexed attribute register.
- R6: While bit 7 of CRT register 17 (0x11) is 1, data writes to CRT registers 0 to 6 are dropped. A data write to CRT register 7 changes only its bit 4. Writes to registers 8 to 24 are not affected.
- R7: The misc register is written at 0x3C2 and read at 0x3CC. Bit 0 = 1 selects the colour set and bit 0 = 0 selects the mono set for the CRT index, CRT data and status ports.
- R8: Ports of the inactive colour/mono set and every unmapped port read 0xFF, and writes to them change nothing. Write-only ports (0x3C2) and read-only ports (0x3C1, 0x3CC, status) also read 0xFF or ignore writes.
- R9: The status port (0x3DA colour, 0x3BA mono) reads bit 0 = `stat_disp_off`, bit 3 = `stat_retrace`, and 0 in all other bits.
- R10: A 16-bit write to any port other than an index port acts as a byte write of bits 7:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Port address of the access |
| io_wdata | input | 16 | Write data; bits 15:8 are used only by 16-bit index-port writes |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wide | input | 1 | Marks the write as 16 bits wide |
| io_rd | input | 1 | Read strobe, one cycle per access |
| stat_retrace | input | 1 | Vertical retrace flag reported in the status port |
| stat_disp_off | input | 1 | Display-inactive flag reported in the status port |
| io_rdata | output | 8 | Read data for the addressed port, valid in the strobe cycle |
| seq_regs | output | 40 | Sequencer registers, register n at bits 8n+7:8n |
| crtc_regs | output | 200 | CRT controller registers, same packing |
| gfx_regs | output | 72 | Graphics controller registers, same packing |
| attr_regs | output | 168 | Attribute controller registers, same packing |
| misc_out | output | 8 | Miscellaneous output register |
| attr_video_en | output | 1 | Bit 5 of the last attribute index write |

## Verification
The assertions assume that `io_rd` and `io_wr` are never high together. The phase-machine properties rely on this, because a status read and an attribute write in one cycle would leave the machine's next state undefined. They also assume that each access lasts one strobe cycle. The bench drives every access as a single strobed cycle between falling edges and never overlaps a read with a write. It samples read data during the strobe and register outputs only after the write edge.

// File: rtl/disp_io_pkg.sv
package disp_io_pkg;

    // Bank sizes
    localparam int SEQ_REGS  = 5;
    localparam int CRT_REGS  = 25;
    localparam int GFX_REGS  = 9;
    localparam int ATR_REGS  = 21;
    localparam int BYTE_W    = 8;

    // CRT protection layout
    localparam int CRT_LOCK_REG  = 17;
    localparam int CRT_LOCK_BIT  = 7;
    localparam int CRT_LOCK_SPAN = 8;
    localparam int CRT_OVF_REG   = 7;
    localparam int CRT_OVF_BIT   = 4;

    // Fixed port addresses
    localparam logic [15:0] P_ATR_IDX  = 16'h03C0;
    localparam logic [15:0] P_ATR_RD   = 16'h03C1;
    localparam logic [15:0] P_MISC_WR  = 16'h03C2;
    localparam logic [15:0] P_SEQ_IDX  = 16'h03C4;
    localparam logic [15:0] P_SEQ_DAT  = 16'h03C5;
    localparam logic [15:0] P_MISC_RD  = 16'h03CC;
    localparam logic [15:0] P_GFX_IDX  = 16'h03CE;
    localparam logic [15:0] P_GFX_DAT  = 16'h03CF;

    // Relocatable port set: upper 12 bits per mode, low nibble per port
    localparam logic [11:0] CRT_HI_COLOR = 12'h03D;
    localparam logic [11:0] CRT_HI_MONO  = 12'h03B;
    localparam logic [3:0]  LO_CRT_IDX   = 4'h4;
    localparam logic [3:0]  LO_CRT_DAT   = 4'h5;
    localparam logic [3:0]  LO_STATUS    = 4'hA;

    localparam logic [7:0]  MISC_RESET   = 8'h01;
    localparam logic [7:0]  OPEN_BUS     = 8'hFF;

    typedef enum logic [3:0] {
        PS_NONE,
        PS_SEQ_I,
        PS_SEQ_D,
        PS_GFX_I,
        PS_GFX_D,
        PS_CRT_I,
        PS_CRT_D,
        PS_ATR_W,
        PS_ATR_R,
        PS_MISC_W,
        PS_MISC_R,
        PS_STAT
    } port_sel_e;

    typedef enum logic {
        AF_INDEX,
        AF_DATA
    } attr_phase_e;

endpackage

// File: rtl/disp_port_decode.sv
module disp_port_decode
    import disp_io_pkg::*;
(
    input  logic [15:0] addr,
    input  logic        color_mode,
    output port_sel_e   sel
);

    logic [11:0] crt_hi;

    always_comb begin
        crt_hi = color_mode ? CRT_HI_COLOR : CRT_HI_MONO;
    end

    always_comb begin
        sel = PS_NONE;
        if (addr[15:4] == crt_hi) begin
            case (addr[3:0])
                LO_CRT_IDX: sel = PS_CRT_I;
                LO_CRT_DAT: sel = PS_CRT_D;
                LO_STATUS:  sel = PS_STAT;
                default:    sel = PS_NONE;
            endcase
        end else begin
            case (addr)
                P_ATR_IDX: sel = PS_ATR_W;
                P_ATR_RD:  sel = PS_ATR_R;
                P_MISC_WR: sel = PS_MISC_W;
                P_SEQ_IDX: sel = PS_SEQ_I;
                P_SEQ_DAT: sel = PS_SEQ_D;
                P_MISC_RD: sel = PS_MISC_R;
                P_GFX_IDX: sel = PS_GFX_I;
                P_GFX_DAT: sel = PS_GFX_D;
                default:   sel = PS_NONE;
            endcase
        end
    end

endmodule

// File: rtl/disp_attr_phase.sv
module disp_attr_phase
    import disp_io_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic attr_wr,
    input  logic stat_rd,
    output logic at_index
);

    attr_phase_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= AF_INDEX;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AF_INDEX: begin
                if (attr_wr && !stat_rd) state_d = AF_DATA;
            end
            AF_DATA: begin
                if (stat_rd || attr_wr)  state_d = AF_INDEX;
            end
        endcase
    end

    // Outputs
    always_comb begin
        at_index = (state_q == AF_INDEX);
    end

    // R5: a status read always leaves the machine ready for an index
    assert_stat_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> at_index);

    // R5: every attribute write flips the phase
    assert_write_toggles_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (attr_wr && !stat_rd) |=> (at_index != $past(at_index)));

endmodule

// File: rtl/disp_idx_bank.sv
module disp_idx_bank #(
    parameter int NREGS     = 5,
    parameter int IDXW      = 8,
    parameter bit LOCKABLE  = 1'b0,
    parameter int LOCK_SPAN = 8,
    parameter int KEEP_REG  = 7,
    parameter int KEEP_BIT  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               idx_we,
    input  logic [7:0]         idx_d,
    input  logic               dat_we,
    input  logic [7:0]         dat_d,
    input  logic               lock,
    output logic [7:0]         idx_q,
    output logic [7:0]         rd_q,
    output logic [NREGS*8-1:0] regs_flat
);

    localparam logic [IDXW:0]   LIMIT    = (IDXW+1)'(NREGS);
    localparam logic [IDXW:0]   SPAN_LIM = (IDXW+1)'(LOCK_SPAN);
    localparam logic [IDXW-1:0] KEEP_IDX = IDXW'(KEEP_REG);
    localparam logic [7:0]      KEEP_MSK = 8'(1 << KEEP_BIT);

    logic [7:0]      r [NREGS];
    logic [IDXW-1:0] tgt;
    logic            in_range;
    logic            lock_hit;
    logic [7:0]      wmask;

    // A combined index+data write targets the new index
    always_comb begin
        tgt      = idx_we ? idx_d[IDXW-1:0] : idx_q[IDXW-1:0];
        in_range = ({1'b0, tgt} < LIMIT);
        lock_hit = LOCKABLE && lock && ({1'b0, tgt} < SPAN_LIM);
        if (!lock_hit)            wmask = 8'hFF;
        else if (tgt == KEEP_IDX) wmask = KEEP_MSK;
        else                      wmask = 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            for (int i = 0; i < NREGS; i++) r[i] <= '0;
        end else begin
            if (idx_we) idx_q <= idx_d;
            for (int i = 0; i < NREGS; i++) begin
                if (dat_we && in_range && (tgt == IDXW'(i)))
                    r[i] <= (r[i] & ~wmask) | (dat_d & wmask);
            end
        end
    end

    // Data read follows the latch; out-of-range reads give zero
    always_comb begin
        rd_q = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (idx_q[IDXW-1:0] == IDXW'(i)) rd_q = r[i];
        end
    end

    for (genvar g = 0; g < NREGS; g++) begin : g_flat
        assign regs_flat[g*8 +: 8] = r[g];
    end

    // R4: writes past the bank end leave every register alone
    assert_range_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && !in_range) |=> $stable(regs_flat));

    if (LOCKABLE) begin : g_lock_chk
        // R6: a locked write touches nothing in the protected span but the kept bit
        assert_lock_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (dat_we && lock_hit) |=>
            $stable({regs_flat[LOCK_SPAN*8-1 : KEEP_REG*8+KEEP_BIT+1],
                     regs_flat[KEEP_REG*8+KEEP_BIT-1 : 0]}));
    end

endmodule

// File: rtl/disp_reg_front.sv
module disp_reg_front
    import disp_io_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [15:0]            io_addr,
    input  logic [15:0]            io_wdata,
    input  logic                   io_wr,
    input  logic                   io_wide,
    input  logic                   io_rd,
    input  logic                   stat_retrace,
    input  logic                   stat_disp_off,
    output logic [7:0]             io_rdata,
    output logic [SEQ_REGS*8-1:0]  seq_regs,
    output logic [CRT_REGS*8-1:0]  crtc_regs,
    output logic [GFX_REGS*8-1:0]  gfx_regs,
    output logic [ATR_REGS*8-1:0]  attr_regs,
    output logic [7:0]             misc_out,
    output logic                   attr_video_en
);

    localparam int ATR_IDXW = 5;
    localparam int LOCK_POS = CRT_LOCK_REG*8 + CRT_LOCK_BIT;

    port_sel_e  sel;
    logic [7:0] lo_b, hi_b;
    logic [7:0] misc_q;
    logic       at_index;
    logic       attr_wr, stat_rd, crt_lock;

    logic       seq_iwe, seq_dwe, gfx_iwe, gfx_dwe, crt_iwe, crt_dwe, atr_iwe, atr_dwe;
    logic [7:0] seq_dd, gfx_dd, crt_dd;
    logic [7:0] seq_idx, seq_rd, gfx_idx, gfx_rd, crt_idx, crt_rd, atr_idx, atr_rd;

    assign lo_b = io_wdata[7:0];
    assign hi_b = io_wdata[15:8];

    disp_port_decode u_decode (
        .addr       (io_addr),
        .color_mode (misc_q[0]),
        .sel        (sel)
    );

    // Strobe steering
    always_comb begin
        seq_iwe = io_wr && (sel == PS_SEQ_I);
        seq_dwe = io_wr && ((sel == PS_SEQ_D) || (seq_iwe && io_wide));
        seq_dd  = seq_iwe ? hi_b : lo_b;
        gfx_iwe = io_wr && (sel == PS_GFX_I);
        gfx_dwe = io_wr && ((sel == PS_GFX_D) || (gfx_iwe && io_wide));
        gfx_dd  = gfx_iwe ? hi_b : lo_b;
        crt_iwe = io_wr && (sel == PS_CRT_I);
        crt_dwe = io_wr && ((sel == PS_CRT_D) || (crt_iwe && io_wide));
        crt_dd  = crt_iwe ? hi_b : lo_b;
        attr_wr = io_wr && (sel == PS_ATR_W);
        atr_iwe = attr_wr && at_index;
        atr_dwe = attr_wr && !at_index;
        stat_rd = io_rd && (sel == PS_STAT);
        crt_lock = crtc_regs[LOCK_POS];
    end

    disp_attr_phase u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .attr_wr  (attr_wr),
        .stat_rd  (stat_rd),
        .at_index (at_index)
    );

    disp_idx_bank #(.NREGS(SEQ_REGS), .IDXW(8)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .idx_we(seq_iwe), .idx_d(lo_b), .dat_we(seq_dwe), .dat_d(seq_dd),
        .lock(1'b0), .idx_q(seq_idx), .rd_q(seq_rd), .regs_flat(seq_regs)
    );

    disp_idx_bank #(.NREGS(GFX_REGS), .IDXW(8)) u_gfx (
        .clk(clk), .rst_n(rst_n),
        .idx_we(gfx_iwe), .idx_d(lo_b), .dat_we(gfx_dwe), .dat_d(gfx_dd),
        .lock(1'b0), .idx_q(gfx_idx), .rd_q(gfx_rd), .regs_flat(gfx_regs)
    );

    disp_idx_bank #(
        .NREGS(CRT_REGS), .IDXW(8), .LOCKABLE(1'b1),
        .LOCK_SPAN(CRT_LOCK_SPAN), .KEEP_REG(CRT_OVF_REG), .KEEP_BIT(CRT_OVF_BIT)
    ) u_crt (
        .clk(clk), .rst_n(rst_n),
        .idx_we(crt_iwe), .idx_d(lo_b), .dat_we(crt_dwe), .dat_d(crt_dd),
        .lock(crt_lock), .idx_q(crt_idx), .rd_q(crt_rd), .regs_flat(crtc_regs)
    );

    disp_idx_bank #(.NREGS(ATR_REGS), .IDXW(ATR_IDXW)) u_atr (
        .clk(clk), .rst_n(rst_n),
        .idx_we(atr_iwe), .idx_d(lo_b), .dat_we(atr_dwe), .dat_d(lo_b),
        .lock(1'b0), .idx_q(atr_idx), .rd_q(atr_rd), .regs_flat(attr_regs)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                          misc_q <= MISC_RESET;
        else if (io_wr && sel == PS_MISC_W)  misc_q <= lo_b;
    end

    always_comb begin
        misc_out      = misc_q;
        attr_video_en = atr_idx[5];
    end

    // Read mux
    always_comb begin
        io_rdata = OPEN_BUS;
        unique case (sel)
            PS_SEQ_I:  io_rdata = seq_idx;
            PS_SEQ_D:  io_rdata = seq_rd;
            PS_GFX_I:  io_rdata = gfx_idx;
            PS_GFX_D:  io_rdata = gfx_rd;
            PS_CRT_I:  io_rdata = crt_idx;
            PS_CRT_D:  io_rdata = crt_rd;
            PS_ATR_W:  io_rdata = atr_idx;
            PS_ATR_R:  io_rdata = atr_rd;
            PS_MISC_R: io_rdata = misc_q;
            PS_STAT:   io_rdata = {4'b0000, stat_retrace, 2'b00, stat_disp_off};
            PS_MISC_W: io_rdata = OPEN_BUS;
            PS_NONE:   io_rdata = OPEN_BUS;
            default:   io_rdata = OPEN_BUS;
        endcase
    end

    // R5: the phase machine is defined only for non-overlapping accesses
    assert_single_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_wr));

    // R7: a misc write lands in the misc register on the next edge
    assert_misc_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && sel == PS_MISC_W) |=> (misc_out == $past(io_wdata[7:0])));

    // R8: a write to an unmapped or inactive port changes no state
    assert_dead_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && sel == PS_NONE) |=>
        ($stable(seq_regs) && $stable(crtc_regs) && $stable(gfx_regs) &&
         $stable(attr_regs) && $stable(misc_out)));

endmodule

// File: tb/test_disp_reg_front.sv
module test_disp_reg_front;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] OP_WB = 2'd0, OP_WW = 2'd1, OP_RD = 2'd2;
    localparam int NV = 64;

    // {op, addr, data, expect, requirement}
    localparam logic [49:0] VECS [NV] = '{
        {OP_RD, 16'h03CC, 16'h0000, 8'h01, 8'd1},   // R1 misc reset
        {OP_RD, 16'h03C4, 16'h0000, 8'h00, 8'd1},   // R1 latch reset
        {OP_WB, 16'h03C4, 16'h0002, 8'h00, 8'd2},
        {OP_RD, 16'h03C4, 16'h0000, 8'h02, 8'd2},   // R2 index readback
        {OP_WB, 16'h03C5, 16'h000F, 8'h00, 8'd2},
        {OP_RD, 16'h03C5, 16'h0000, 8'h0F, 8'd2},   // R2 data readback
        {OP_WW, 16'h03CE, 16'h5508, 8'h00, 8'd3},
        {OP_RD, 16'h03CE, 16'h0000, 8'h08, 8'd3},   // R3 index part
        {OP_RD, 16'h03CF, 16'h0000, 8'h55, 8'd3},   // R3 data part
        {OP_WB, 16'h03C4, 16'h0007, 8'h00, 8'd4},
        {OP_WB, 16'h03C5, 16'h00AA, 8'h00, 8'd4},
        {OP_RD, 16'h03C5, 16'h0000, 8'h00, 8'd4},   // R4 out-of-range read
        {OP_RD, 16'h03C4, 16'h0000, 8'h07, 8'd2},
        {OP_WB, 16'h03C4, 16'h0002, 8'h00, 8'd4},
        {OP_RD, 16'h03C5, 16'h0000, 8'h0F, 8'd4},   // R4 no side effect
        {OP_WW, 16'h03D4, 16'h3307, 8'h00, 8'd3},
        {OP_RD, 16'h03D5, 16'h0000, 8'h33, 8'd3},
        {OP_WW, 16'h03D4, 16'h8011, 8'h00, 8'd6},
        {OP_RD, 16'h03D5, 16'h0000, 8'h80, 8'd6},
        {OP_WW, 16'h03D4, 16'h7700, 8'h00, 8'd6},
        {OP_RD, 16'h03D5, 16'h0000, 8'h00, 8'd6},   // R6 reg0 locked
        {OP_WW, 16'h03D4, 16'hEF07, 8'h00, 8'd6},
        {OP_RD, 16'h03D5, 16'h0000, 8'h23, 8'd6},   // R6 only bit4 of reg7
        {OP_WW, 16'h03D4, 16'h4412, 8'h00, 8'd6},
        {OP_RD, 16'h03D5, 16'h0000, 8'h44, 8'd6},   // R6 high regs free
        {OP_WW, 16'h03D4, 16'h0011, 8'h00, 8'd6},
        {OP_WW, 16'h03D4, 16'h9900, 8'h00, 8'd6},
        {OP_RD, 16'h03D5, 16'h0000, 8'h99, 8'd6},   // R6 unlocked again
        {OP_RD, 16'h03B4, 16'h0000, 8'hFF, 8'd8},   // R8 mono idle in colour
        {OP_WB, 16'h03B5, 16'h0012, 8'h00, 8'd8},
        {OP_RD, 16'h03D5, 16'h0000, 8'h99, 8'd8},
        {OP_RD, 16'h03DA, 16'h0000, 8'h00, 8'd9},   // R9 status clear
        {OP_WB, 16'h03C0, 16'h0003, 8'h00, 8'd5},
        {OP_WB, 16'h03C0, 16'h003C, 8'h00, 8'd5},
        {OP_RD, 16'h03C1, 16'h0000, 8'h3C, 8'd5},   // R5 data phase
        {OP_RD, 16'h03C0, 16'h0000, 8'h03, 8'd5},
        {OP_WB, 16'h03C0, 16'h0025, 8'h00, 8'd5},
        {OP_WB, 16'h03C0, 16'h0011, 8'h00, 8'd5},
        {OP_RD, 16'h03C1, 16'h0000, 8'h11, 8'd5},
        {OP_RD, 16'h03C0, 16'h0000, 8'h25, 8'd5},
        {OP_WB, 16'h03C0, 16'h0024, 8'h00, 8'd5},
        {OP_RD, 16'h03DA, 16'h0000, 8'h00, 8'd5},   // R5 mid-pair clear
        {OP_WB, 16'h03C0, 16'h0006, 8'h00, 8'd5},
        {OP_RD, 16'h03C0, 16'h0000, 8'h06, 8'd5},
        {OP_RD, 16'h03C1, 16'h0000, 8'h00, 8'd5},
        {OP_RD, 16'h03DA, 16'h0000, 8'h00, 8'd5},
        {OP_WB, 16'h03C0, 16'h0016, 8'h00, 8'd4},
        {OP_WB, 16'h03C0, 16'h005A, 8'h00, 8'd4},
        {OP_RD, 16'h03C1, 16'h0000, 8'h00, 8'd4},   // R4 attr index 22
        {OP_WB, 16'h03C2, 16'h0000, 8'h00, 8'd7},
        {OP_RD, 16'h03CC, 16'h0000, 8'h00, 8'd7},   // R7 mono selected
        {OP_RD, 16'h03D4, 16'h0000, 8'hFF, 8'd8},
        {OP_RD, 16'h03B5, 16'h0000, 8'h99, 8'd7},
        {OP_RD, 16'h03B4, 16'h0000, 8'h00, 8'd7},
        {OP_RD, 16'h03DA, 16'h0000, 8'hFF, 8'd8},
        {OP_RD, 16'h03BA, 16'h0000, 8'h00, 8'd9},
        {OP_WW, 16'h03B5, 16'hAB10, 8'h00, 8'd10},
        {OP_RD, 16'h03B5, 16'h0000, 8'h10, 8'd10},  // R10 wide to data port
        {OP_WB, 16'h03C2, 16'h0001, 8'h00, 8'd7},
        {OP_RD, 16'h03CC, 16'h0000, 8'h01, 8'd7},
        {OP_RD, 16'h03C3, 16'h0000, 8'hFF, 8'd8},   // R8 unmapped
        {OP_RD, 16'h03C2, 16'h0000, 8'hFF, 8'd8},
        {OP_WB, 16'h03CC, 16'h0055, 8'h00, 8'd8},
        {OP_RD, 16'h03CC, 16'h0000, 8'h01, 8'd8}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [15:0]  io_addr = '0;
    logic [15:0]  io_wdata = '0;
    logic         io_wr = 1'b0, io_wide = 1'b0, io_rd = 1'b0;
    logic         stat_retrace = 1'b0, stat_disp_off = 1'b0;
    logic [7:0]   io_rdata;
    logic [39:0]  seq_regs;
    logic [199:0] crtc_regs;
    logic [71:0]  gfx_regs;
    logic [167:0] attr_regs;
    logic [7:0]   misc_out;
    logic         attr_video_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_reg_front i_disp_reg_front (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_wide(io_wide), .io_rd(io_rd),
        .stat_retrace(stat_retrace), .stat_disp_off(stat_disp_off),
        .io_rdata(io_rdata), .seq_regs(seq_regs), .crtc_regs(crtc_regs),
        .gfx_regs(gfx_regs), .attr_regs(attr_regs), .misc_out(misc_out),
        .attr_video_en(attr_video_en)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic wr_port(input logic [15:0] a, input logic [15:0] d, input bit wide);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wide = wide; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_wide = 1'b0;
    endtask

    task automatic rd_port(input logic [15:0] a, input logic [7:0] exp, input int req);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 check(io_rdata, exp, req, $sformatf("read %04h", a));
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values on the parallel outputs
        @(negedge clk);
        check(crtc_regs[7:0], 8'h00, 1, "crtc reg0 after reset");
        check(misc_out, 8'h01, 1, "misc after reset");

        for (int v = 0; v < NV; v++) begin
            logic [49:0] e;
            e = VECS[v];
            case (e[49:48])
                OP_WB: wr_port(e[47:32], e[31:16], 1'b0);
                OP_WW: wr_port(e[47:32], e[31:16], 1'b1);
                default: rd_port(e[47:32], e[15:8], int'(e[7:0]));
            endcase
        end

        // R2 R3 R6 R10: register contents on the parallel outputs
        @(negedge clk);
        check(seq_regs[23:16], 8'h0F, 2, "seq reg2 field");
        check(gfx_regs[71:64], 8'h55, 3, "gfx reg8 field");
        check(crtc_regs[63:56], 8'h23, 6, "crtc reg7 field");
        check(crtc_regs[7:0], 8'h10, 10, "crtc reg0 field");
        // R5: attribute fields and display enable
        check(attr_regs[31:24], 8'h3C, 5, "attr reg3 field");
        check(attr_regs[47:40], 8'h11, 5, "attr reg5 field");
        check(attr_regs[39:32], 8'h00, 5, "attr reg4 untouched");
        check({7'd0, attr_video_en}, 8'h00, 5, "video enable low");
        rd_port(16'h03DA, 8'h00, 5);
        wr_port(16'h03C0, 16'h0020, 1'b0);
        @(negedge clk);
        check({7'd0, attr_video_en}, 8'h01, 5, "video enable high");

        // R9: status bits follow their inputs
        stat_retrace = 1'b1; stat_disp_off = 1'b1;
        rd_port(16'h03DA, 8'h09, 9);
        stat_retrace = 1'b0;
        rd_port(16'h03DA, 8'h01, 9);

        // R1: reset mid-run restores defaults and index phase
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(crtc_regs[63:56], 8'h00, 1, "crtc reg7 after reset");
        check(misc_out, 8'h01, 1, "misc after second reset");
        check({7'd0, attr_video_en}, 8'h00, 1, "video enable after reset");
        wr_port(16'h03C0, 16'h0001, 1'b0);
        rd_port(16'h03C0, 8'h01, 1);
        rd_port(16'h03C5, 8'h00, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule